// File: doc/BRIEF.md
# Loopback Stream Packing Comparator

The block checks a serial loopback path. A transmit stream and the stream that returns from the loopback each deliver 16-bit words in their own clock domain. Each side gathers four qualified words into one 64-bit entry. It places the first word of a group in the lowest lane and each later word one lane higher. The entry is then written into a dual-clock FIFO for that side.

A third clock, the compare clock, reads both FIFOs in the same cycle. It does so only when neither FIFO is empty, so an entry that is ahead on one side waits for its partner. Because of this, any fixed latency around the loop is absorbed without configuration.

Each pair of entries read together is compared. A difference produces a one-cycle error pulse. It also sets a sticky flag and increments a 32-bit mismatch counter. The flag and the counter are cleared together by a synchronous clear input. Each FIFO holds 16 entries. A write attempted while a FIFO is full is dropped, and it sets a sticky overflow flag for that side.

Top module: `loopback_pack_cmp`

## Requirements
- R1: After reset, err_pulse_o, err_sticky_o, mismatch_cnt_o, tx_ovf_o and rx_ovf_o are all zero.
- R2: A word is taken only in a cycle where its side's valid input is high. Data presented while valid is low has no effect on any compare result.
- R3: A group of fewer than four words is held and never written or compared. The group is compared only once its fourth word arrives.
- R4: Both FIFOs are read in the same compare-clock cycle, and only when both are non-empty. Entries on one side wait for their partners, and no entry is compared against anything but the entry of the same index on the other side.
- R5: Identical word streams produce no error for any fixed offset between the transmit and receive sides, and for any pattern of valid gaps.
- R6: Each pair of compared entries that differ yields exactly one cycle of err_pulse_o. The counter advances by one in that same cycle. Word order matters: the first word of a group occupies bits [15:0] and the fourth occupies bits [63:48].
- R7: err_sticky_o stays high after a mismatch until clear_i. With clear_i high at a compare-clock edge, err_sticky_o and mismatch_cnt_o are zero after that edge.
- R8: Each FIFO holds 16 entries. A 17th unread entry is dropped and sets that side's overflow flag, which stays set until reset. The other side's flag is unaffected.
- R9: The transmit, receive and compare clocks are unrelated. Results do not depend on their ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk_i | input | 1 | Transmit-side word clock |
| tx_rst_ni | input | 1 | Transmit-side asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit word qualifier |
| tx_data_i | input | 16 | Transmit word |
| rx_clk_i | input | 1 | Receive-side word clock |
| rx_rst_ni | input | 1 | Receive-side asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive word qualifier |
| rx_data_i | input | 16 | Returned word |
| cmp_clk_i | input | 1 | Compare clock |
| cmp_rst_ni | input | 1 | Compare-side asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of sticky error and counter |
| err_pulse_o | output | 1 | One-cycle pulse per mismatching pair |
| err_sticky_o | output | 1 | Sticky mismatch flag |
| mismatch_cnt_o | output | 32 | Count of mismatching pairs |
| tx_ovf_o | output | 1 | Sticky transmit FIFO overflow (transmit domain) |
| rx_ovf_o | output | 1 | Sticky receive FIFO overflow (receive domain) |

## Verification
The bench delays the receive stream against the transmit stream and inserts valid gaps that carry junk data. A packer that sampled junk or lost a lane would report false mismatches. It swaps two words within a group, which only a design with a symmetric lane fault would miss. It also leaves three-word partial groups open with a difference, which would count early if a partial group leaked into a FIFO. It then runs one side ahead by two entries, where a reader that popped each FIFO independently would misalign every later pair. Finally it fills one FIFO to exactly 16 entries and then adds a 17th, to catch an off-by-one full flag or an overflow flag on the wrong side.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned LANES      = 4;
  localparam int unsigned ENTRY_W    = WORD_W * LANES;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned CNT_W      = 32;
  localparam int unsigned N_SIDES    = 2;
  localparam int unsigned SIDE_TX    = 0;
  localparam int unsigned SIDE_RX    = 1;
endpackage

// File: rtl/lpc_sync2.sv
`timescale 1ns/1ps
module lpc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/lpc_packer.sv
`timescale 1ns/1ps
module lpc_packer #(
  parameter int unsigned WORD_W = lpc_pkg::WORD_W,
  parameter int unsigned LANES  = lpc_pkg::LANES,
  localparam int unsigned LW      = $clog2(LANES),
  localparam int unsigned ENTRY_W = WORD_W * LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [WORD_W-1:0]  data_i,
  output logic               wr_o,
  output logic [ENTRY_W-1:0] entry_o
);
  logic [LW-1:0]                  lane_q;
  logic [LANES-1:0][WORD_W-1:0]   hold_q;
  logic [LANES-1:0][WORD_W-1:0]   asm;

  // last lane comes straight from the input word
  for (genvar g = 0; g < LANES; g++) begin : g_asm
    if (g == LANES - 1) begin : g_last
      assign asm[g] = data_i;
    end else begin : g_held
      assign asm[g] = hold_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= '0;
      hold_q  <= '0;
      wr_o    <= 1'b0;
      entry_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (valid_i) begin
        hold_q[lane_q] <= data_i;
        if (lane_q == LW'(LANES - 1)) begin
          wr_o    <= 1'b1;
          entry_o <= asm;
          lane_q  <= '0;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  AST_ONE_WRITE_PER_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R3
endmodule

// File: rtl/lpc_async_fifo.sv
`timescale 1ns/1ps
module lpc_async_fifo #(
  parameter int unsigned W     = lpc_pkg::ENTRY_W,
  parameter int unsigned DEPTH = lpc_pkg::FIFO_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic         wclk_i,
  input  logic         wrst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  output logic         ovf_o,
  input  logic         rclk_i,
  input  logic         rrst_ni,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, wgray_nx, rgray_sync;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, rgray_nx, wgray_sync;
  logic          wr_ok, rd_ok;

  assign wr_ok    = wr_i & ~full_o;
  assign wbin_nx  = wbin_q + PW'(wr_ok);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wgray_nx;
      full_o  <= (wgray_nx == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
      if (wr_i && full_o) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  lpc_sync2 #(.W(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rgray_q), .q_o(rgray_sync));
  lpc_sync2 #(.W(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(wgray_q), .q_o(wgray_sync));

  assign rd_ok    = rd_i & ~empty_o;
  assign rbin_nx  = rbin_q + PW'(rd_ok);
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
  assign rdata_o  = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_o <= 1'b1;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rgray_nx;
      empty_o <= (rgray_nx == wgray_sync);
    end
  end

  AST_OVF_STICKY: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    ovf_o |=> ovf_o); // R8
  AST_FULL_HOLDS_PTR: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_o |=> $stable(wgray_q) || !$past(wr_i)); // R8
  AST_NO_POP_EMPTY: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    rd_i |-> !empty_o); // R4
endmodule

// File: rtl/lpc_pair_compare.sv
`timescale 1ns/1ps
module lpc_pair_compare #(
  parameter int unsigned W     = lpc_pkg::ENTRY_W,
  parameter int unsigned CNT_W = lpc_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             a_empty_i,
  input  logic [W-1:0]     a_data_i,
  input  logic             b_empty_i,
  input  logic [W-1:0]     b_data_i,
  output logic             pop_o,
  output logic             err_pulse_o,
  output logic             err_sticky_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic diff;

  assign pop_o = ~a_empty_i & ~b_empty_i;
  assign diff  = pop_o && (a_data_i != b_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pulse_o  <= 1'b0;
      err_sticky_o <= 1'b0;
      cnt_o        <= '0;
    end else begin
      err_pulse_o <= diff;
      if (clear_i) begin
        err_sticky_o <= 1'b0;
        cnt_o        <= '0;
      end else if (diff) begin
        err_sticky_o <= 1'b1;
        cnt_o        <= cnt_o + 1'b1;
      end
    end
  end

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o && !$past(clear_i) |-> err_sticky_o); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> cnt_o == $past(cnt_o) + CNT_W'(err_pulse_o)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_o == '0 && !err_sticky_o); // R7
endmodule

// File: rtl/loopback_pack_cmp.sv
`timescale 1ns/1ps
module loopback_pack_cmp
  import lpc_pkg::*;
(
  input  logic              tx_clk_i,
  input  logic              tx_rst_ni,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              rx_clk_i,
  input  logic              rx_rst_ni,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  input  logic              cmp_clk_i,
  input  logic              cmp_rst_ni,
  input  logic              clear_i,
  output logic              err_pulse_o,
  output logic              err_sticky_o,
  output logic [CNT_W-1:0]  mismatch_cnt_o,
  output logic              tx_ovf_o,
  output logic              rx_ovf_o
);
  logic [N_SIDES-1:0]              s_clk, s_rst_n, s_valid, s_wr, s_ovf, s_full, s_empty;
  logic [N_SIDES-1:0][WORD_W-1:0]  s_data;
  logic [N_SIDES-1:0][ENTRY_W-1:0] s_entry, s_rdata;
  logic                            pop;

  assign s_clk   = {rx_clk_i,   tx_clk_i};
  assign s_rst_n = {rx_rst_ni,  tx_rst_ni};
  assign s_valid = {rx_valid_i, tx_valid_i};
  assign s_data  = {rx_data_i,  tx_data_i};

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    lpc_packer #(.WORD_W(WORD_W), .LANES(LANES)) u_pack (
      .clk_i  (s_clk[s]),
      .rst_ni (s_rst_n[s]),
      .valid_i(s_valid[s]),
      .data_i (s_data[s]),
      .wr_o   (s_wr[s]),
      .entry_o(s_entry[s])
    );
    lpc_async_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .wclk_i (s_clk[s]),
      .wrst_ni(s_rst_n[s]),
      .wr_i   (s_wr[s]),
      .wdata_i(s_entry[s]),
      .full_o (s_full[s]),
      .ovf_o  (s_ovf[s]),
      .rclk_i (cmp_clk_i),
      .rrst_ni(cmp_rst_ni),
      .rd_i   (pop),
      .rdata_o(s_rdata[s]),
      .empty_o(s_empty[s])
    );
  end

  lpc_pair_compare #(.W(ENTRY_W), .CNT_W(CNT_W)) u_cmp (
    .clk_i       (cmp_clk_i),
    .rst_ni      (cmp_rst_ni),
    .clear_i     (clear_i),
    .a_empty_i   (s_empty[SIDE_TX]),
    .a_data_i    (s_rdata[SIDE_TX]),
    .b_empty_i   (s_empty[SIDE_RX]),
    .b_data_i    (s_rdata[SIDE_RX]),
    .pop_o       (pop),
    .err_pulse_o (err_pulse_o),
    .err_sticky_o(err_sticky_o),
    .cnt_o       (mismatch_cnt_o)
  );

  assign tx_ovf_o = s_ovf[SIDE_TX];
  assign rx_ovf_o = s_ovf[SIDE_RX];
endmodule

// File: tb/loopback_pack_cmp_tb_top.sv
`timescale 1ns/1ps
module loopback_pack_cmp_tb_top;
  logic tx_clk = 0, rx_clk = 0, cmp_clk = 0;
  logic tx_rst_n = 0, rx_rst_n = 0, cmp_rst_n = 0;
  logic tx_valid = 0, rx_valid = 0, clear = 0;
  logic [15:0] tx_data = 0, rx_data = 0;
  logic err_pulse, err_sticky, tx_ovf, rx_ovf;
  logic [31:0] mcnt;

  always #10 cmp_clk = ~cmp_clk;  // 50 MHz
  always #8  tx_clk  = ~tx_clk;
  always #11 rx_clk  = ~rx_clk;

  loopback_pack_cmp dut_i (
    .tx_clk_i(tx_clk), .tx_rst_ni(tx_rst_n), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .rx_clk_i(rx_clk), .rx_rst_ni(rx_rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .cmp_clk_i(cmp_clk), .cmp_rst_ni(cmp_rst_n), .clear_i(clear),
    .err_pulse_o(err_pulse), .err_sticky_o(err_sticky), .mismatch_cnt_o(mcnt),
    .tx_ovf_o(tx_ovf), .rx_ovf_o(rx_ovf));

  int checks = 0, errors = 0;
  logic [15:0] tx_acc[$], rx_acc[$];
  logic [63:0] tx_ent[$], rx_ent[$];
  int exp_total = 0;
  int pulses = 0;
  logic [31:0] prev_cnt = 0;
  logic prev_clear = 0;
  bit live = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model: pair entries as soon as both sides have one
  function automatic void pair_up();
    while (tx_ent.size() > 0 && rx_ent.size() > 0) begin
      logic [63:0] a = tx_ent.pop_front();
      logic [63:0] b = rx_ent.pop_front();
      if (a != b) exp_total++;
    end
  endfunction

  function automatic logic [63:0] pack4(ref logic [15:0] q[$]);
    logic [63:0] e;
    for (int i = 0; i < 4; i++) e[i*16 +: 16] = q.pop_front();
    return e;
  endfunction

  task automatic tx_word(input logic [15:0] w, input int gap);
    repeat (gap) @(posedge tx_clk);
    @(negedge tx_clk); tx_valid = 1; tx_data = w;
    @(posedge tx_clk); #1 tx_valid = 0; tx_data = 16'($urandom);
    tx_acc.push_back(w);
    if (tx_acc.size() == 4) begin tx_ent.push_back(pack4(tx_acc)); pair_up(); end
  endtask

  task automatic rx_word(input logic [15:0] w, input int gap);
    repeat (gap) @(posedge rx_clk);
    @(negedge rx_clk); rx_valid = 1; rx_data = w;
    @(posedge rx_clk); #1 rx_valid = 0; rx_data = 16'($urandom);
    rx_acc.push_back(w);
    if (rx_acc.size() == 4) begin rx_ent.push_back(pack4(rx_acc)); pair_up(); end
  endtask

  task automatic settle();
    repeat (60) @(posedge cmp_clk);
    @(negedge cmp_clk);
  endtask

  task automatic do_clear();
    @(negedge cmp_clk); clear = 1;
    @(negedge cmp_clk); clear = 0;
    exp_total = 0; pulses = 0;
  endtask

  // per-clock checks in the compare domain
  always @(negedge cmp_clk) begin
    if (live) begin
      if (!prev_clear) check(mcnt == prev_cnt + 32'(err_pulse), "R6 step", mcnt, prev_cnt + 32'(err_pulse));
      check(int'(mcnt) <= exp_total, "R4 bound", mcnt, exp_total);
      if (err_pulse) pulses++;
    end
    prev_cnt   = mcnt;
    prev_clear = clear;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w[$];
    #55;
    tx_rst_n = 1; rx_rst_n = 1; cmp_rst_n = 1;
    repeat (3) @(posedge cmp_clk);
    @(negedge cmp_clk);
    // R1
    check(mcnt == 0 && !err_pulse && !err_sticky, "R1 cmp reset", mcnt, 0);
    check(!tx_ovf && !rx_ovf, "R1 ovf reset", {tx_ovf, rx_ovf}, 0);
    live = 1;

    // R2 R5: equal streams, offset and junk gaps
    w.delete();
    for (int i = 0; i < 32; i++) w.push_back(16'($urandom));
    fork
      foreach (w[i]) tx_word(w[i], $urandom_range(0, 3));
      begin repeat (7) @(posedge rx_clk); foreach (w[i]) rx_word(w[i], $urandom_range(0, 2)); end
    join
    settle();
    check(mcnt == 0 && !err_sticky, "R5 offset match", mcnt, 0);
    check(pulses == 0, "R2 gaps ignored", pulses, 0);

    // R6: swapped word order, and lane 3 difference
    fork
      begin tx_word(16'h1111,0); tx_word(16'h2222,0); tx_word(16'h3333,0); tx_word(16'h4444,0);
            tx_word(16'hA0,0); tx_word(16'hA1,0); tx_word(16'hA2,0); tx_word(16'hA3,0); end
      begin rx_word(16'h2222,1); rx_word(16'h1111,0); rx_word(16'h3333,0); rx_word(16'h4444,0);
            rx_word(16'hA0,0); rx_word(16'hA1,0); rx_word(16'hA2,0); rx_word(16'hA4,0); end
    join
    settle();
    check(mcnt == 2, "R6 order/lane3", mcnt, 2);
    check(pulses == 2, "R6 pulses", pulses, 2);
    check(err_sticky, "R7 sticky", err_sticky, 1);

    // R7 clear
    do_clear();
    @(negedge cmp_clk);
    check(mcnt == 0 && !err_sticky, "R7 clear", mcnt, 0);

    // R3: partial groups with a difference are held
    fork
      begin tx_word(16'h0001,0); tx_word(16'h0002,0); tx_word(16'h0003,0); end
      begin rx_word(16'h0001,0); rx_word(16'hFFFF,0); rx_word(16'h0003,0); end
    join
    settle();
    check(mcnt == 0 && pulses == 0, "R3 partial held", mcnt, 0);
    fork tx_word(16'h0004,0); rx_word(16'h0004,0); join
    settle();
    check(mcnt == 1, "R3 group done", mcnt, 1);

    // R4: transmit runs two entries ahead, partner waits
    for (int i = 0; i < 8; i++) tx_word(16'(16'h5000 + i), 0);
    settle();
    check(mcnt == 1, "R4 lone side", mcnt, 1);
    for (int i = 0; i < 8; i++) rx_word((i == 1) ? 16'hDEAD : 16'(16'h5000 + i), 0);
    settle();
    check(mcnt == 2, "R4 paired late", mcnt, 2);

    // R9: long random run with corruption
    w.delete();
    for (int i = 0; i < 80; i++) w.push_back(16'($urandom));
    fork
      foreach (w[i]) tx_word(w[i], $urandom_range(0, 1));
      begin repeat (13) @(posedge rx_clk);
        foreach (w[i]) rx_word(($urandom_range(0, 9) == 0) ? ~w[i] : w[i], $urandom_range(0, 4)); end
    join
    settle();
    check(int'(mcnt) == exp_total, "R9 random", mcnt, exp_total);
    check(pulses == exp_total, "R6 random pulses", pulses, exp_total);

    // R8: fill transmit FIFO to depth, then one more
    do_clear();
    for (int i = 0; i < 64; i++) tx_word(16'(i), 0);
    settle();
    check(!tx_ovf, "R8 exact depth", tx_ovf, 0);
    for (int i = 0; i < 4; i++) tx_word(16'(i), 0);
    settle();
    check(tx_ovf, "R8 overflow", tx_ovf, 1);
    check(!rx_ovf, "R8 other side", rx_ovf, 0);
    check(mcnt == 0, "R4 no compare", mcnt, 0);

    // R1: reset clears overflow
    live = 0;
    tx_rst_n = 0; rx_rst_n = 0; cmp_rst_n = 0;
    #100;
    tx_rst_n = 1; rx_rst_n = 1; cmp_rst_n = 1;
    @(negedge cmp_clk);
    check(!tx_ovf && !rx_ovf && mcnt == 0, "R1 re-reset", tx_ovf, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule